// File: doc/BRIEF.md
# Masked Packed 64-bit Integer to Single-Precision Converter

This block turns a vector of signed 64-bit integers into IEEE single-precision values, one result per lane. Each result is half as wide as its source element, so the result vector fills only the lower half of the selected vector length. A per-lane write mask decides which lanes take their new value. A lane whose mask bit is clear either keeps the previous destination contents or is cleared, depending on the zeroing select. A broadcast option feeds the lowest source element to every lane.

A request is a one-cycle `in_valid` pulse. The result, the inexact flag and the undefined-opcode flag are registered on that edge and appear with `out_valid` one cycle later. A small two-state control machine produces the valid output. `ST_IDLE` moves to `ST_EMIT` on the transition *accept*, which happens when `in_valid` is high. `ST_EMIT` goes back to `ST_IDLE` on the transition *retire* when no new request arrives. It stays in `ST_EMIT` on the transition *chain* when a back-to-back request arrives.

Top module: `packed_i64_to_f32`

## Requirements
- R1: `vl_sel` picks the lane count: code 0 gives 2 lanes (128-bit source), code 1 gives 4 lanes (256-bit), and codes 2 and 3 give 8 lanes (512-bit).
- R2: Lane j reads `src_vec[64j+63:64j]` and writes `result[32j+31:32j]`.
- R3: An active lane takes its converted value when `mask_en` is 0, or when `lane_mask[j]` is 1.
- R4: An active lane whose mask bit is 0 while `mask_en` is 1 keeps `old_dst[32j+31:32j]` when `zero_mode` is 0. It becomes 0 when `zero_mode` is 1.
- R5: When `bcast_en` is 1, every written lane converts `src_vec[63:0]`.
- R6: All result bits from 32 × (lane count) up to bit 255 are 0.
- R7: If `rsv_field` is not 4'b1111, `undef_op` is 1, `inexact` is 0, and `result` keeps its previous value. Otherwise `undef_op` is 0.
- R8: The rounding mode is `rm_sel` only when `rm_override` is 1, `vl_sel` selects 8 lanes and `mem_form` is 0. In every other case it is round-to-nearest-even. `rm_sel` encodes 0 as nearest-even, 1 as toward minus infinity, 2 as toward plus infinity and 3 as toward zero.
- R9: Conversion follows the two's-complement value and rounds to a 24-bit significand in the selected mode. An input of 0 gives +0.0. An input of -2^63 gives sign 1, exponent 190, fraction 0, with no inexact flag.
- R10: `inexact` is the OR of the inexactness of the written lanes only. Masked-off and inactive lanes do not contribute.
- R11: After reset, `out_valid`, `result`, `inexact` and `undef_op` are 0. Each `in_valid` pulse gives exactly one `out_valid` cycle on the following cycle, carrying that request's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request pulse |
| src_vec | input | 512 | Packed signed 64-bit source elements |
| old_dst | input | 256 | Previous destination contents used for merging |
| lane_mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | 1 = apply `lane_mask`, 0 = write all active lanes |
| zero_mode | input | 1 | 1 = clear masked lanes, 0 = keep old contents |
| bcast_en | input | 1 | Feed element 0 to every lane |
| vl_sel | input | 2 | Vector length code |
| rm_sel | input | 2 | Requested rounding mode |
| rm_override | input | 1 | Request an explicit rounding mode |
| mem_form | input | 1 | Source came from memory (blocks the override) |
| rsv_field | input | 4 | Reserved field, must be all ones |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 256 | Packed single-precision results |
| inexact | output | 1 | Some written lane was rounded |
| undef_op | output | 1 | Reserved field was not all ones |

## Verification
The checker watches properties that hold on every cycle. It confirms that a request is always followed by a valid cycle, and that a rejected reserved field flags an error, suppresses the inexact flag and leaves the result unchanged. It checks that a fully masked zeroing request yields an all-zero result with no inexact flag. It also checks that the bits above half the selected length stay clear. The actual numeric values only show up in the bench's sweep, which compares each lane against an arithmetic reference model. That sweep covers every vector length, every mask and merge/zero/broadcast combination, and all four rounding modes with the override gating. It also covers edge values such as ties, -2^63 and 2^63-1.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_DOWN      = 2'd1,
        RM_UP        = 2'd2,
        RM_ZERO      = 2'd3
    } rnd_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } cvt_state_t;
endpackage

// File: rtl/lane_i64_to_f32.sv
module lane_i64_to_f32
    import cvt_pkg::*;
#(
    parameter int IN_W  = 64,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [IN_W-1:0]            value,
    input  rnd_mode_t                  rm,
    output logic [EXP_W+MAN_W:0]       fp,
    output logic                       inexact
);
    localparam int POS_W = $clog2(IN_W);
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

    logic             neg;
    logic [IN_W-1:0]  mag;
    logic [IN_W-1:0]  norm;
    logic [POS_W-1:0] lead;
    logic [MAN_W:0]   keep;
    logic             guard;
    logic             sticky;
    logic             inc;
    logic [MAN_W+1:0] sum;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;

    assign neg = value[IN_W-1];
    assign mag = neg ? (~value + 1'b1) : value;

    always_comb begin
        lead = '0;
        for (int k = 0; k < IN_W; k++) begin
            if (mag[k]) lead = POS_W'(k);
        end
    end

    assign norm   = mag << (POS_W'(IN_W - 1) - lead);
    assign keep   = norm[IN_W-1 -: MAN_W+1];
    assign guard  = norm[IN_W-MAN_W-2];
    assign sticky = |norm[IN_W-MAN_W-3:0];

    always_comb begin
        unique case (rm)
            RM_NEAR_EVEN: inc = guard & (sticky | keep[0]);
            RM_DOWN:      inc = neg & (guard | sticky);
            RM_UP:        inc = ~neg & (guard | sticky);
            default:      inc = 1'b0;
        endcase
    end

    assign sum  = {1'b0, keep} + (MAN_W+2)'(inc);
    assign expo = EXP_W'(BIAS) + EXP_W'(lead) + EXP_W'(sum[MAN_W+1]);
    assign frac = sum[MAN_W+1] ? '0 : sum[MAN_W-1:0];

    assign fp      = (mag == '0) ? '0 : {neg, expo, frac};
    assign inexact = (mag != '0) & (guard | sticky);
endmodule

// File: rtl/lane_gate.sv
module lane_gate #(
    parameter int W = 32
) (
    input  logic         active,
    input  logic         write,
    input  logic         zero_mode,
    input  logic [W-1:0] conv,
    input  logic         conv_inx,
    input  logic [W-1:0] old,
    output logic [W-1:0] lane_out,
    output logic         lane_inx
);
    always_comb begin
        lane_out = '0;
        lane_inx = 1'b0;
        if (active) begin
            if (write) begin
                lane_out = conv;
                lane_inx = conv_inx;
            end else if (!zero_mode) begin
                lane_out = old;
            end
        end
    end
endmodule

// File: rtl/packed_i64_to_f32.sv
module packed_i64_to_f32
    import cvt_pkg::*;
#(
    parameter int MAX_LANES = 8,
    parameter int SRC_W     = 64,
    parameter int DST_W     = 32,
    parameter int RSV_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [MAX_LANES*SRC_W-1:0] src_vec,
    input  logic [MAX_LANES*DST_W-1:0] old_dst,
    input  logic [MAX_LANES-1:0]       lane_mask,
    input  logic                       mask_en,
    input  logic                       zero_mode,
    input  logic                       bcast_en,
    input  logic [1:0]                 vl_sel,
    input  logic [1:0]                 rm_sel,
    input  logic                       rm_override,
    input  logic                       mem_form,
    input  logic [RSV_W-1:0]           rsv_field,
    output logic                       out_valid,
    output logic [MAX_LANES*DST_W-1:0] result,
    output logic                       inexact,
    output logic                       undef_op
);
    localparam int RES_W = MAX_LANES * DST_W;
    localparam int CNT_W = $clog2(MAX_LANES + 1);

    cvt_state_t             state_q, state_d;
    logic [CNT_W-1:0]       lane_cnt;
    rnd_mode_t              eff_rm;
    logic                   rsv_ok;
    logic [RES_W-1:0]       res_comb;
    logic [MAX_LANES-1:0]   inx_lane;
    logic [RES_W-1:0]       res_q;
    logic                   inx_q;
    logic                   ud_q;

    always_comb begin
        unique case (vl_sel)
            2'd0:    lane_cnt = CNT_W'(MAX_LANES / 4);
            2'd1:    lane_cnt = CNT_W'(MAX_LANES / 2);
            default: lane_cnt = CNT_W'(MAX_LANES);
        endcase
    end

    assign eff_rm = (rm_override && vl_sel[1] && !mem_form) ? rnd_mode_t'(rm_sel) : RM_NEAR_EVEN;
    assign rsv_ok = (rsv_field == {RSV_W{1'b1}});

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        logic [SRC_W-1:0] lane_src;
        logic [DST_W-1:0] conv;
        logic             conv_inx;

        assign lane_src = bcast_en ? src_vec[SRC_W-1:0] : src_vec[j*SRC_W +: SRC_W];

        lane_i64_to_f32 #(.IN_W(SRC_W), .EXP_W(8), .MAN_W(DST_W - 9)) u_conv (
            .value   (lane_src),
            .rm      (eff_rm),
            .fp      (conv),
            .inexact (conv_inx)
        );

        lane_gate #(.W(DST_W)) u_gate (
            .active    (CNT_W'(j) < lane_cnt),
            .write     (!mask_en || lane_mask[j]),
            .zero_mode (zero_mode),
            .conv      (conv),
            .conv_inx  (conv_inx),
            .old       (old_dst[j*DST_W +: DST_W]),
            .lane_out  (res_comb[j*DST_W +: DST_W]),
            .lane_inx  (inx_lane[j])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: accept / chain / retire
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            inx_q <= 1'b0;
            ud_q  <= 1'b0;
        end else if (in_valid) begin
            if (rsv_ok) begin
                res_q <= res_comb;
                inx_q <= |inx_lane;
                ud_q  <= 1'b0;
            end else begin
                inx_q <= 1'b0;
                ud_q  <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        out_valid = (state_q == ST_EMIT);
        result    = res_q;
        inexact   = inx_q;
        undef_op  = ud_q;
    end
endmodule

// File: rtl/packed_i64_to_f32_chk.sv
module packed_i64_to_f32_chk #(
    parameter int MAX_LANES = 8,
    parameter int DST_W     = 32,
    parameter int RSV_W     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [MAX_LANES-1:0]       lane_mask,
    input logic                       mask_en,
    input logic                       zero_mode,
    input logic [1:0]                 vl_sel,
    input logic [RSV_W-1:0]           rsv_field,
    input logic                       out_valid,
    input logic [MAX_LANES*DST_W-1:0] result,
    input logic                       inexact,
    input logic                       undef_op
);
    localparam int RES_W = MAX_LANES * DST_W;
    localparam int Q_W   = (MAX_LANES / 4) * DST_W;
    localparam int H_W   = (MAX_LANES / 2) * DST_W;

    // R11
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    bad_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsv_field != {RSV_W{1'b1}}) |=> (undef_op && !inexact && $stable(result)));

    // R7
    good_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsv_field == {RSV_W{1'b1}}) |=> !undef_op);

    // R4
    all_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsv_field == {RSV_W{1'b1}} && mask_en && zero_mode && lane_mask == '0)
        |=> (result == '0));

    // R10
    masked_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && lane_mask == '0) |=> !inexact);

    // R6
    upper_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsv_field == {RSV_W{1'b1}} && vl_sel == 2'd0) |=> (result[RES_W-1:Q_W] == '0));

    // R6
    upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsv_field == {RSV_W{1'b1}} && vl_sel == 2'd1) |=> (result[RES_W-1:H_W] == '0));
endmodule

bind packed_i64_to_f32 packed_i64_to_f32_chk #(
    .MAX_LANES(MAX_LANES), .DST_W(DST_W), .RSV_W(RSV_W)
) chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_mask(lane_mask),
    .mask_en(mask_en), .zero_mode(zero_mode), .vl_sel(vl_sel),
    .rsv_field(rsv_field), .out_valid(out_valid), .result(result),
    .inexact(inexact), .undef_op(undef_op)
);

// File: tb/packed_i64_to_f32_test.sv
module packed_i64_to_f32_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_vec = '0;
    logic [255:0] old_dst = '0;
    logic [7:0]   lane_mask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic         bcast_en = 1'b0;
    logic [1:0]   vl_sel = '0;
    logic [1:0]   rm_sel = '0;
    logic         rm_override = 1'b0;
    logic         mem_form = 1'b0;
    logic [3:0]   rsv_field = 4'hF;
    logic         out_valid;
    logic [255:0] result;
    logic         inexact;
    logic         undef_op;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    packed_i64_to_f32 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .old_dst(old_dst), .lane_mask(lane_mask), .mask_en(mask_en),
        .zero_mode(zero_mode), .bcast_en(bcast_en), .vl_sel(vl_sel),
        .rm_sel(rm_sel), .rm_override(rm_override), .mem_form(mem_form),
        .rsv_field(rsv_field), .out_valid(out_valid), .result(result),
        .inexact(inexact), .undef_op(undef_op)
    );

    function automatic logic [63:0] next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    function automatic logic [63:0] pick_value(input int idx);
        logic [63:0] r;
        r = next_rng();
        case (idx % 12)
            0:  return 64'd0;
            1:  return 64'hFFFF_FFFF_FFFF_FFFF;
            2:  return 64'h8000_0000_0000_0000;
            3:  return 64'h7FFF_FFFF_FFFF_FFFF;
            4:  return 64'd16777217;
            5:  return -64'sd16777219;
            6:  return 64'd33554435;
            7:  return 64'h00FF_FFFF_FFFF_FFFF;
            default: return r >> r[5:0];
        endcase
    endfunction

    // Reference: {inexact, float}
    function automatic logic [32:0] ref_cvt(input logic [63:0] x, input logic [1:0] rm);
        logic        neg;
        logic [63:0] mag, q, r, half;
        int          p, sh;
        logic        up;
        logic [7:0]  e;
        if (x == 64'd0) return 33'd0;
        neg = x[63];
        mag = neg ? (64'd0 - x) : x;
        p = 0;
        for (int k = 0; k < 64; k++) if (mag[k]) p = k;
        if (p <= 23) begin
            q = mag << (23 - p);
            r = 64'd0;
            up = 1'b0;
        end else begin
            sh = p - 23;
            q = mag >> sh;
            r = mag - (q << sh);
            half = 64'd1 << (sh - 1);
            case (rm)
                2'd0: up = (r > half) || (r == half && q[0]);
                2'd1: up = neg && (r != 0);
                2'd2: up = !neg && (r != 0);
                default: up = 1'b0;
            endcase
        end
        q = q + {63'd0, up};
        e = 8'(127 + p);
        if (q == 64'd16777216) begin
            q = 64'd8388608;
            e = e + 8'd1;
        end
        return {r != 64'd0, neg, e, q[22:0]};
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_one(input int seed);
        logic [255:0] exp_res;
        logic         exp_inx;
        logic [1:0]   erm;
        logic [32:0]  c;
        logic [63:0]  s;
        int           lanes;
        for (int j = 0; j < 8; j++) src_vec[j*64 +: 64] = pick_value(seed + j);
        old_dst = {next_rng(), next_rng(), next_rng(), next_rng()};
        rsv_field = 4'hF;
        lanes = 2 << vl_sel;
        erm = (rm_override && vl_sel == 2'd2 && !mem_form) ? rm_sel : 2'd0;
        exp_res = '0;
        exp_inx = 1'b0;
        for (int j = 0; j < lanes; j++) begin
            s = bcast_en ? src_vec[63:0] : src_vec[j*64 +: 64];
            if (!mask_en || lane_mask[j]) begin
                c = ref_cvt(s, erm);
                exp_res[j*32 +: 32] = c[31:0];
                exp_inx = exp_inx | c[32];
            end else if (!zero_mode) begin
                exp_res[j*32 +: 32] = old_dst[j*32 +: 32];
            end
        end
        issue();
        // R1 R2 R3 R4 R5 R6 R8 R9: lane values and upper clearing
        check("R9", result, exp_res);
        // R10
        check("R10", {255'd0, inexact}, {255'd0, exp_inx});
        // R11
        check("R11", {254'd0, out_valid, undef_op}, {254'd0, 1'b1, 1'b0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [255:0] held;
        int seed;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {255'd0, out_valid}, 256'd0);
        check("R11", result, 256'd0);
        check("R11", {254'd0, inexact, undef_op}, 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {255'd0, out_valid}, 256'd0);

        // R9: fixed corner values on 8 lanes, no mask
        vl_sel = 2'd2; mask_en = 1'b0; bcast_en = 1'b0; rm_override = 1'b0;
        src_vec = '0;
        src_vec[63:0]    = 64'h8000_0000_0000_0000;
        src_vec[127:64]  = 64'd0;
        src_vec[191:128] = 64'd16777217;
        rsv_field = 4'hF;
        issue();
        check("R9", {224'd0, result[31:0]}, {224'd0, 32'hDF00_0000});
        check("R9", {224'd0, result[63:32]}, 256'd0);
        check("R9", {224'd0, result[95:64]}, {224'd0, 32'h4B80_0000});
        check("R10", {255'd0, inexact}, {255'd0, 1'b1});
        @(negedge clk);
        // R11: valid lasts one cycle
        check("R11", {255'd0, out_valid}, 256'd0);

        // Sweep
        seed = 0;
        for (int v = 0; v < 3; v++) begin
            for (int m = 0; m < 8; m++) begin
                for (int mi = 0; mi < 16; mi++) begin
                    for (int r = 0; r < 4; r++) begin
                        vl_sel = 2'(v);
                        mask_en = m[0];
                        zero_mode = m[1];
                        bcast_en = m[2];
                        lane_mask = 8'(mi * 17);
                        rm_sel = 2'(r);
                        rm_override = r[0] ^ mi[0] ^ 1'b1;
                        mem_form = mi[1] & mi[2];
                        run_one(seed);
                        seed = seed + 3;
                    end
                end
            end
        end

        // R7: every non-all-ones reserved value
        for (int k = 0; k < 15; k++) begin
            vl_sel = 2'd2; mask_en = 1'b0;
            run_one(seed);
            seed = seed + 5;
            held = result;
            src_vec = {8{64'd12345}};
            rsv_field = 4'(k);
            issue();
            check("R7", result, held);
            check("R7", {254'd0, undef_op, inexact}, {254'd0, 1'b1, 1'b0});
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule